// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Sequencer

This block sits between a clocked host and a 128K-word by 16-bit asynchronous static RAM. The host offers one request at a time through a request/ready handshake. A request carries a read or write flag, a 17-bit word address, 16 bits of write data and a two-bit lane mask. The sequencer then plays out the memory's control pattern over several clock cycles: chip select, write strobe, output enable and two active-low byte-lane enables. It also switches a tri-state data bus that is split into separate out, in and drive-enable signals.

Each phase of an access lasts a set number of clock cycles. These counts are parameters, and their defaults are computed from nanosecond limits and the clock period, rounded up with a floor of one cycle:

- the read phase from the address access time;
- the setup phase from the address setup time;
- the write strobe from the write-pulse width with output enable held high;
- the read-to-write turnaround from the bus release time.

Output enable stays high for the whole of every write, so the shorter pulse rule applies. A read followed by a write gets extra idle cycles so that the memory has released the bus before the controller drives it. Read data is registered and returned with a one-cycle valid strobe. A request whose lane mask is all zero completes without touching the memory.

Top module: `sram_byte_ctl`

## Requirements
- R1: During reset and in the first cycle after it, chip select, write strobe, output enable and both lane enables are high, the bus drive is off, ready is high and read-valid is low.
- R2: Ready is high only while the block is idle. A request is taken at a clock edge where request and ready are both high, and ready is low from the next cycle until the access ends. Counted in cycles after the accepting edge, ready returns after:
  - RD_CYC+1 for a read;
  - SU_CYC+PW_CYC+1 for a write;
  - TURN_CYC+SU_CYC+PW_CYC+1 for a write whose previously accepted request was a read with a nonzero mask;
  - 2 for a zero-mask request.
- R3: A read holds chip select and output enable low and the write strobe high for exactly RD_CYC cycles. The address stays stable while chip select is low, and the bus is sampled at the clock edge that ends the read phase.
- R4: Mask bit 0 selects the lower lane (data bits 7:0, lane enable bit 0) and mask bit 1 selects the upper lane (bits 15:8, lane enable bit 1). A lane enable is driven low exactly when its mask bit is 1. Read data for an unselected lane is returned as zero. Read-valid is high for exactly one cycle, which is the cycle in which ready returns.
- R5: A write holds chip select and the lane enables low with the write strobe high for SU_CYC cycles, then holds the write strobe low for PW_CYC cycles. Output enable stays high throughout the write.
- R6: The bus drive is on only while the write strobe and chip select are low and output enable is high. It is never on while output enable is low.
- R7: A write changes only the lanes its mask selects. The other lane of the addressed word keeps its previous value.
- R8: A request with an all-zero mask asserts none of chip select, write strobe, output enable or the lane enables, and it raises no read-valid.
- R9: After a read with a nonzero mask, the next accepted request, if it is a write, waits TURN_CYC extra cycles with chip select high before its setup phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request present |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| host_ready | output | 1 | Idle and able to accept a request |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | One-cycle read data strobe |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Lane enables, active low, bit 0 lower byte |
| sram_dq_out | output | 16 | Data driven onto the bus |
| sram_dq_oe | output | 1 | Bus drive enable |
| sram_dq_in | input | 16 | Data read from the bus |

## Verification
A phase counter loaded with the wrong value shows up within the same access. The read window, setup run or strobe width measured at the memory pins comes out wrong, and ready returns on the wrong cycle. A stale read-then-write flag shows up on the next write as a missing or surplus turnaround in the accept-to-ready latency. A wrong lane decode corrupts a neighbouring byte. That fault stays silent until the word is read back, so every random write is later checked against a shadow copy through full and partial reads.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W = 17;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SKIP,
        PH_TURN,
        PH_READ,
        PH_WSETUP,
        PH_WPULSE
    } phase_e;

    typedef struct packed {
        logic  wr;
        addr_t addr;
        word_t data;
        lane_t mask;
    } op_t;

    typedef struct packed {
        logic  ce_n;
        logic  we_n;
        logic  oe_n;
        lane_t be_n;
        logic  drive;
    } pins_t;

    localparam pins_t PINS_IDLE = '{
        ce_n:  1'b1,
        we_n:  1'b1,
        oe_n:  1'b1,
        be_n:  {LANES{1'b1}},
        drive: 1'b0
    };

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(int t_ns, int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Pin pattern for each phase; the lane enables follow the mask.
    function automatic pins_t decode_pins(phase_e ph, lane_t mask);
        pins_t p;
        p = PINS_IDLE;
        unique case (ph)
            PH_READ: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
                p.be_n = ~mask;
            end
            PH_WSETUP: begin
                p.ce_n = 1'b0;
                p.be_n = ~mask;
            end
            PH_WPULSE: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.be_n  = ~mask;
                p.drive = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R3
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes
    import sram_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  lane_t mask,
    input  word_t bus_in,
    output word_t rdata,
    output logic  rvalid
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (cap) begin
                lane_q <= mask[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= cap;
        end
    end

    // R4
    rvalid_once_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 1,
    parameter int SU_CYC   = 1,
    parameter int PW_CYC   = 1,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  op_t              req_op,
    input  logic             t_done,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             ready,
    output logic             cap,
    output op_t              op_q,
    output pins_t            pins_q
);

    phase_e ph;
    phase_e ph_nx;
    op_t    op_nx;
    logic   last_rd;
    logic   accept;

    assign ready  = (ph == PH_IDLE);
    assign accept = ready && req;

    always_comb begin
        ph_nx  = ph;
        op_nx  = op_q;
        t_load = 1'b0;
        t_val  = '0;
        cap    = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                if (accept) begin
                    op_nx = req_op;
                    if (req_op.mask == '0) begin
                        ph_nx = PH_SKIP;
                    end else if (!req_op.wr) begin
                        ph_nx  = PH_READ;
                        t_load = 1'b1;
                        t_val  = CNT_W'(RD_CYC - 1);
                    end else if (last_rd) begin
                        ph_nx  = PH_TURN;
                        t_load = 1'b1;
                        t_val  = CNT_W'(TURN_CYC - 1);
                    end else begin
                        ph_nx  = PH_WSETUP;
                        t_load = 1'b1;
                        t_val  = CNT_W'(SU_CYC - 1);
                    end
                end
            end
            PH_SKIP: ph_nx = PH_IDLE;
            PH_TURN: begin
                if (t_done) begin
                    ph_nx  = PH_WSETUP;
                    t_load = 1'b1;
                    t_val  = CNT_W'(SU_CYC - 1);
                end
            end
            PH_READ: begin
                if (t_done) begin
                    ph_nx = PH_IDLE;
                    cap   = 1'b1;
                end
            end
            PH_WSETUP: begin
                if (t_done) begin
                    ph_nx  = PH_WPULSE;
                    t_load = 1'b1;
                    t_val  = CNT_W'(PW_CYC - 1);
                end
            end
            PH_WPULSE: begin
                if (t_done) ph_nx = PH_IDLE;
            end
            default: ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            op_q    <= '0;
            pins_q  <= PINS_IDLE;
            last_rd <= 1'b0;
        end else begin
            ph     <= ph_nx;
            op_q   <= op_nx;
            pins_q <= decode_pins(ph_nx, op_nx.mask);
            if (cap) begin
                last_rd <= 1'b1;
            end else if (accept) begin
                last_rd <= 1'b0;
            end
        end
    end

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

endmodule

// File: rtl/sram_byte_ctl.sv
module sram_byte_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int T_ACC_NS  = 10,
    parameter int T_AS_NS   = 0,
    parameter int T_WP_NS   = 8,
    parameter int T_DS_NS   = 5,
    parameter int T_REL_NS  = 5,
    parameter int RD_CYC    = ns_to_cycles(T_ACC_NS, CLK_NS),
    parameter int SU_CYC    = ns_to_cycles(T_AS_NS, CLK_NS),
    parameter int PW_CYC    = ns_to_cycles(max2(T_WP_NS, T_DS_NS), CLK_NS),
    parameter int TURN_CYC  = ns_to_cycles(T_REL_NS, CLK_NS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_mask,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [LANES-1:0]  sram_be_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int MAX_CYC = max2(max2(RD_CYC, SU_CYC), max2(PW_CYC, TURN_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    op_t              req_op;
    op_t              op_q;
    pins_t            pins_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             cap;

    assign req_op = '{wr: host_wr, addr: host_addr, data: host_wdata, mask: host_mask};

    sram_ctl_seq #(
        .RD_CYC   (RD_CYC),
        .SU_CYC   (SU_CYC),
        .PW_CYC   (PW_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) i_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (host_req),
        .req_op (req_op),
        .t_done (t_done),
        .t_load (t_load),
        .t_val  (t_val),
        .ready  (host_ready),
        .cap    (cap),
        .op_q   (op_q),
        .pins_q (pins_q)
    );

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_ctl_lanes i_lanes (
        .clk    (clk),
        .rst    (rst),
        .cap    (cap),
        .mask   (op_q.mask),
        .bus_in (sram_dq_in),
        .rdata  (host_rdata),
        .rvalid (host_rvalid)
    );

    assign sram_addr   = op_q.addr;
    assign sram_dq_out = op_q.data;
    assign sram_ce_n   = pins_q.ce_n;
    assign sram_we_n   = pins_q.we_n;
    assign sram_oe_n   = pins_q.oe_n;
    assign sram_be_n   = pins_q.be_n;
    assign sram_dq_oe  = pins_q.drive;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sram_ce_n && sram_we_n && sram_oe_n && (sram_be_n == '1)
                        && !sram_dq_oe && host_ready && !host_rvalid));

    // R2
    busy_while_selected_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> !host_ready);

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R5
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && op_q.wr));

    // R5
    pulse_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $past(!sram_ce_n));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> !sram_dq_oe);

    // R6
    drive_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (!sram_we_n && !sram_ce_n));

    // R8
    lane_needed_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> (sram_be_n != '1));

endmodule

// File: tb/test_sram_byte_ctl.sv
module test_sram_byte_ctl;
    import sram_ctl_pkg::*;

    localparam int RD = 3;
    localparam int SU = 2;
    localparam int PW = 2;
    localparam int TN = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_req;
    logic        host_wr;
    logic [16:0] host_addr;
    logic [15:0] host_wdata;
    logic [1:0]  host_mask;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [16:0] sram_addr;
    logic        sram_ce_n;
    logic        sram_we_n;
    logic        sram_oe_n;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_in;

    sram_byte_ctl #(
        .RD_CYC   (RD),
        .SU_CYC   (SU),
        .PW_CYC   (PW),
        .TURN_CYC (TN)
    ) i_sram_byte_ctl (
        .clk         (clk),
        .rst         (rst),
        .host_req    (host_req),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_mask   (host_mask),
        .host_ready  (host_ready),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .sram_addr   (sram_addr),
        .sram_ce_n   (sram_ce_n),
        .sram_we_n   (sram_we_n),
        .sram_oe_n   (sram_oe_n),
        .sram_be_n   (sram_be_n),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe),
        .sram_dq_in  (sram_dq_in)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Memory device model and independent shadow copy
    logic [15:0] dev_mem [int];
    logic [15:0] exp_mem [int];

    function automatic logic [15:0] seed_word(int a);
        return 16'(a * 40503) ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] dev_word(int a);
        return dev_mem.exists(a) ? dev_mem[a] : seed_word(a);
    endfunction

    function automatic logic [15:0] exp_word(int a);
        return exp_mem.exists(a) ? exp_mem[a] : seed_word(a);
    endfunction

    function automatic logic [15:0] lane_keep(logic [15:0] w, logic [1:0] m);
        logic [15:0] r;
        r[7:0]  = m[0] ? w[7:0]  : 8'h00;
        r[15:8] = m[1] ? w[15:8] : 8'h00;
        return r;
    endfunction

    always_comb begin
        logic [15:0] w;
        w = dev_word(int'(sram_addr));
        for (int l = 0; l < 2; l++) begin
            sram_dq_in[l*8 +: 8] = (!sram_ce_n && sram_we_n && !sram_oe_n && !sram_be_n[l])
                                   ? w[l*8 +: 8] : 8'hC3;
        end
    end

    // Pin monitor, sampled away from the active edge
    int oe_run = 0;
    int we_run = 0;
    int ce_run = 0;
    bit prev_we_n = 1'b1;
    bit quiet_op = 1'b0;
    int strobe_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            logic [15:0] w;
            if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
                w = dev_word(int'(sram_addr));
                for (int l = 0; l < 2; l++)
                    if (!sram_be_n[l]) w[l*8 +: 8] = sram_dq_out[l*8 +: 8];
                dev_mem[int'(sram_addr)] = w;
            end
            if (sram_dq_oe)  // R6
                check(!sram_we_n && !sram_ce_n && sram_oe_n, "R6", "drive outside strobe",
                      {sram_ce_n, sram_we_n, sram_oe_n}, 3'b001);
            if (!sram_oe_n) begin
                oe_run++;
            end else if (oe_run != 0) begin
                check(oe_run == RD, "R3", "read window length", oe_run, RD);
                oe_run = 0;
            end
            if (!sram_we_n) begin
                if (prev_we_n)
                    check(ce_run == SU, "R5", "setup cycles before strobe", ce_run, SU);
                we_run++;
            end else if (we_run != 0) begin
                check(we_run == PW, "R5", "write strobe length", we_run, PW);
                we_run = 0;
            end
            if (!sram_ce_n) ce_run++;
            else ce_run = 0;
            prev_we_n = sram_we_n;
            if (quiet_op && (!sram_ce_n || !sram_we_n || !sram_oe_n || sram_be_n != 2'b11))
                strobe_seen++;
        end
    end

    bit prev_rd = 1'b0;

    // Issue one request from a negedge; returns at the negedge where ready is back.
    task automatic do_op(bit wr, logic [16:0] a, logic [15:0] d, logic [1:0] m);
        int lat;
        int exp_lat;
        bit zero;
        logic [15:0] expw;
        zero = (m == 2'b00);
        if (zero) exp_lat = 2;
        else if (!wr) exp_lat = RD + 1;
        else if (prev_rd) exp_lat = TN + SU + PW + 1;
        else exp_lat = SU + PW + 1;
        quiet_op = zero;
        strobe_seen = 0;
        host_req = 1'b1;
        host_wr = wr;
        host_addr = a;
        host_wdata = d;
        host_mask = m;
        while (!host_ready) @(negedge clk);
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ready && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, (wr && prev_rd && !zero) ? "R9" : "R2", "accept to ready cycles",
              lat, exp_lat);
        check(host_rvalid == (!wr && !zero), "R4", "read-valid with ready", host_rvalid,
              (!wr && !zero));
        if (!wr && !zero) begin
            expw = lane_keep(exp_word(int'(a)), m);
            check(host_rdata == expw, (m == 2'b11) ? "R7" : "R4", "read data", host_rdata, expw);
        end
        if (zero) check(strobe_seen == 0, "R8", "strobes during zero-mask request",
                        strobe_seen, 0);
        if (wr && !zero) begin
            expw = exp_word(int'(a));
            if (m[0]) expw[7:0] = d[7:0];
            if (m[1]) expw[15:8] = d[15:8];
            exp_mem[int'(a)] = expw;
        end
        quiet_op = 1'b0;
        prev_rd = !wr && !zero;
        if (!wr && !zero) begin
            @(negedge clk);
            check(!host_rvalid, "R4", "read-valid one cycle", host_rvalid, 0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        rst = 1'b1;
        host_req = 1'b0;
        host_wr = 1'b0;
        host_addr = '0;
        host_wdata = '0;
        host_mask = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11 && !sram_dq_oe,
              "R1", "strobes in reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe},
              6'b111110);
        rst = 1'b0;
        @(negedge clk);
        // R1 first cycle after reset
        check(host_ready && !host_rvalid && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe,
              "R1", "idle after reset", {host_ready, host_rvalid, sram_ce_n, sram_dq_oe}, 4'b1010);

        // Directed corner cases
        do_op(1'b1, 17'h00010, 16'h1234, 2'b11);   // R5 full write
        do_op(1'b0, 17'h00010, 16'h0000, 2'b11);   // R3 R7 full read
        do_op(1'b1, 17'h00010, 16'hABCD, 2'b01);   // R7 lower lane only
        do_op(1'b0, 17'h00010, 16'h0000, 2'b11);   // upper lane kept
        do_op(1'b0, 17'h00010, 16'h0000, 2'b10);   // R4 lower lane returns zero
        do_op(1'b1, 17'h00010, 16'hFFFF, 2'b00);   // R8 zero-mask write
        do_op(1'b0, 17'h00010, 16'h0000, 2'b11);   // R8 word unchanged
        do_op(1'b0, 17'h00010, 16'h0000, 2'b00);   // R8 zero-mask read, no valid
        do_op(1'b0, 17'h1FFFF, 16'h0000, 2'b01);   // R9 read then write
        do_op(1'b1, 17'h1FFFF, 16'h5AA5, 2'b10);
        do_op(1'b1, 17'h1FFFF, 16'h0F0F, 2'b01);   // write after write, no turnaround
        do_op(1'b0, 17'h1FFFF, 16'h0000, 2'b11);

        // Constrained random mix over a small address window
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            a = {($urandom % 2 == 0) ? 1'b0 : 1'b1, 11'h000, 5'($urandom % 24)};
            do_op(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
        end

        // Final readback of the whole window
        for (int i = 0; i < 24; i++) begin
            do_op(1'b0, 17'(i), 16'h0000, 2'b11);
            do_op(1'b0, {1'b1, 11'h000, 5'(i)}, 16'h0000, 2'b11);
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule